// File: doc/BRIEF.md
# Deficiency-Based Binary Squarer

This block squares an unsigned N-bit operand (N of 4, 8 or 16 by parameter) into a 2N-bit result, without a general N-by-N multiplier. The operand is measured against the base 2^(N-1). When the top bit is set, the deficiency is the operand's low N-1 bits. When the top bit is clear, the deficiency is the (N-1)-bit two's complement of those low bits. Only this (N-1)-bit deficiency is squared, by a column-wise (vertical-and-crosswise) array. The low N-1 bits of that inner square go straight to the result. The upper half of the inner square forms a carry word. The carry word is then added to a correction term, or a correction term is subtracted from it, to build the upper result bits.

The top-bit-set path adds the operand, the deficiency and the carry word. The top-bit-clear path forms the low bits minus the deficiency. If that difference is non-negative, it is added to the carry word. If it is negative, its magnitude is subtracted from the carry word. A parameter places an optional output register, loaded by a valid strobe, after the combinational result, for timing closure.

Top module: `deficiency_squarer`

## Requirements
- R1: For every operand value, `square` equals operand × operand, as an unsigned 2N-bit number.
- R2: An operand with bit N-1 set gives a result of at least 2^(2N-2), so bits 2N-1..2N-2 of `square` are not both zero.
- R3: An operand with bit N-1 clear gives a result that is zero-extended: bits 2N-1 and 2N-2 of `square` are both 0.
- R4: An operand of 0 gives a `square` of 0, even though its deficiency wraps to 0.
- R5: The all-ones operand 2^N-1 gives 2^(2N) - 2^(N+1) + 1, with no overflow out of 2N bits.
- R6: The operand 2^(N-1) (zero deficiency on the set-MSB path) gives exactly 2^(2N-2).
- R7: The operand 1 (largest deficiency, negative difference) gives 1.
- R8: With REG_OUT=1, `outValid` is 0 while reset is held, and `square` is 0 then. `outValid` and `square` show the result one clock edge after `inValid` is sampled high.
- R9: With REG_OUT=0, `square` follows `operand` combinationally, and `outValid` equals `inValid` in the same cycle.
- R10: With REG_OUT=1, while `inValid` is low, changes on `operand` have no effect: `square` holds its last value and `outValid` is 0.
- R11: Bit 0 of `square` equals bit 0 of the operand, and bit 1 of `square` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand is valid this cycle |
| operand | input | N | Unsigned operand |
| outValid | output | 1 | Result on `square` is valid |
| square | output | 2N | Unsigned square of the operand |

## Verification
On every cycle with a valid operand, the assertions check the structural facts of the combinational result: the parity and bit-1 rule, the zero-extension of top-bit-clear results, the floor of top-bit-set results, and zero mapping to zero. They also check the one-cycle valid timing and that the register holds while no load strobe is present. Exact equality with the product, and the specific corner values, can only be shown by the bench's scenarios. The bench sweeps every operand at N=4 (unregistered) and N=8 (registered), adds a pseudo-random set plus corners at N=16, and covers the hold behaviour with `inValid` low.

// File: rtl/defsq_pkg.sv
package defsq_pkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic loadEn;   // capture the combinational square into the output register
  } sqStrobes_t;
endpackage

// File: rtl/defsq_inner.sv
// Column-wise (vertical and crosswise) squarer of an M-bit deficiency.
module defsq_inner #(
  parameter int M = 7
) (
  input  logic [M-1:0]   defic,
  output logic [2*M-1:0] dsq
);
  localparam int PW = 2 * M;
  localparam int CW = $clog2(M + 1);

  logic [CW-1:0] colSum;
  logic [PW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < 2 * M - 1; k++) begin
      colSum = '0;
      for (int i = 0; i < M; i++) begin
        if ((k - i) >= 0 && (k - i) < M)
          colSum = colSum + CW'(defic[i] & defic[k - i]);
      end
      acc = acc + (PW'(colSum) << k);
    end
  end

  assign dsq = acc;
endmodule

// File: rtl/defsq_datapath.sv
module defsq_datapath
  import defsq_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  sqStrobes_t     strobes,
  input  logic [N-1:0]   operand,
  output logic [2*N-1:0] square
);
  localparam int M  = N - 1;     // deficiency width
  localparam int UW = N + 1;     // upper result width
  localparam int SW = M + 2;     // signed difference width

  logic            msb;
  logic [M-1:0]    lowBits;
  logic [M-1:0]    defic;
  logic [2*M-1:0]  dsq;
  logic [M-1:0]    carryW;
  logic [UW-1:0]   upperAdd;
  logic [UW-1:0]   upperSub;
  logic signed [SW-1:0] diffY;
  logic [SW-1:0]   diffMag;
  logic [UW-1:0]   upper;
  logic [2*N-1:0]  sqComb;

  assign msb     = operand[N-1];
  assign lowBits = operand[M-1:0];

  // Deficiency: low bits above the base, or the wrapped complement below it
  assign defic = msb ? lowBits : (~lowBits + M'(1));

  defsq_inner #(.M(M)) inner_i (
    .defic (defic),
    .dsq   (dsq)
  );

  assign carryW = dsq[2*M-1:M];

  // Set-MSB path: operand + deficiency + carry word
  assign upperAdd = UW'(operand) + UW'(defic) + UW'(carryW);

  // Clear-MSB path: difference of low bits and deficiency, sign picks add or subtract
  assign diffY   = $signed({2'b00, lowBits}) - $signed({2'b00, defic});
  assign diffMag = diffY[SW-1] ? SW'(-diffY) : SW'(diffY);
  assign upperSub = diffY[SW-1] ? (UW'(carryW) - UW'(diffMag[M-1:0]))
                                : (UW'(carryW) + UW'(diffMag[M-1:0]));

  assign upper  = msb ? upperAdd : upperSub;
  assign sqComb = {upper, dsq[M-1:0]};

  assert_parity_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (sqComb[0] == operand[0]) && (sqComb[1] == 1'b0));

  assert_mode2_narrow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !operand[N-1]) |-> (sqComb[2*N-1:2*N-2] == 2'b00));

  assert_mode1_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && operand[N-1]) |-> (sqComb[2*N-1:2*N-2] != 2'b00));

  assert_zero_in_zero_out_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && operand == '0) |-> (sqComb == '0));

  generate
    if (REG_OUT) begin : g_reg
      logic [2*N-1:0] sqReg;
      always_ff @(posedge clk) begin
        if (!rstN)               sqReg <= '0;
        else if (strobes.loadEn) sqReg <= sqComb;
      end
      assign square = sqReg;

      assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.loadEn |=> $stable(sqReg));
    end else begin : g_comb
      assign square = sqComb;
    end
  endgenerate
endmodule

// File: rtl/defsq_control.sv
module defsq_control
  import defsq_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output sqStrobes_t strobes,
  output logic       outValid
);
  assign strobes.loadEn = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/deficiency_squarer.sv
module deficiency_squarer
  import defsq_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [N-1:0]   operand,
  output logic           outValid,
  output logic [2*N-1:0] square
);
  sqStrobes_t strobes;

  defsq_control #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  defsq_datapath #(.N(N), .REG_OUT(REG_OUT)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .operand (operand),
    .square  (square)
  );
endmodule

// File: tb/deficiency_squarer_tb_top.sv
module deficiency_squarer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0]  op8 = '0;
  logic [3:0]  op4 = '0;
  logic [15:0] op16 = '0;
  logic        ov8, ov4, ov16;
  logic [15:0] sq8;
  logic [7:0]  sq4;
  logic [31:0] sq16;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  deficiency_squarer #(.N(8), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(op8),
    .outValid(ov8), .square(sq8));

  deficiency_squarer #(.N(4), .REG_OUT(1'b0)) dut4_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(op4),
    .outValid(ov4), .square(sq4));

  deficiency_squarer #(.N(16), .REG_OUT(1'b1)) dut16_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(op16),
    .outValid(ov16), .square(sq16));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] held;
    // Reset state (R8)
    repeat (3) @(negedge clk);
    chk(ov8 == 1'b0, "R8", ov8, 0);
    chk(sq8 == 16'd0, "R8", sq8, 0);
    rstN = 1'b1;

    // Exhaustive N=8 registered, N=4 combinational
    for (int a = 0; a < 256; a++) begin
      inValid = 1'b1;
      op8 = 8'(a);
      op16 = 16'(a);
      if (a < 16) begin
        op4 = 4'(a);
        #1;
        chk(sq4 == 8'(a * a), "R9", sq4, a * a);
        chk(ov4 == 1'b1, "R9", ov4, 1);
      end
      @(negedge clk);
      chk(ov8 == 1'b1, "R8", ov8, 1);
      chk(sq8 == 16'(a * a), "R1", sq8, a * a);
      chk(sq16 == 32'(a * a), "R1", sq16, a * a);
      if (a >= 128) chk(sq8[15:14] != 2'b00, "R2", sq8, a * a);
      else          chk(sq8[15:14] == 2'b00, "R3", sq8, a * a);
      chk(sq8[0] == op8[0] && sq8[1] == 1'b0, "R11", sq8, a * a);
      if (a == 0)   chk(sq8 == 16'd0, "R4", sq8, 0);
      if (a == 255) chk(sq8 == 16'd65025, "R5", sq8, 65025);
      if (a == 128) chk(sq8 == 16'd16384, "R6", sq8, 16384);
      if (a == 1)   chk(sq8 == 16'd1, "R7", sq8, 1);
    end

    // N=16 corners and pseudo-random operands
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      longint e;
      case (n)
        0: op16 = 16'h0000;
        1: op16 = 16'h0001;
        2: op16 = 16'h8000;
        3: op16 = 16'hFFFF;
        4: op16 = 16'h7FFF;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          op16 = lfsr;
        end
      endcase
      e = longint'(op16) * longint'(op16);
      @(negedge clk);
      chk(sq16 == 32'(e), "R1", sq16, e);
      if (n == 0) chk(sq16 == 32'd0, "R4", sq16, 0);
      if (n == 2) chk(sq16 == 32'h4000_0000, "R6", sq16, 32'h4000_0000);
      if (n == 3) chk(sq16 == 32'hFFFE_0001, "R5", sq16, 32'hFFFE_0001);
    end

    // Hold while inValid low (R10); combinational unit tracks (R9)
    op8 = 8'd13;
    @(negedge clk);
    held = sq8;
    chk(held == 16'd169, "R1", held, 169);
    inValid = 1'b0;
    op8 = 8'd200;
    op4 = 4'd5;
    #1;
    chk(ov4 == 1'b0, "R9", ov4, 0);
    chk(sq4 == 8'd25, "R9", sq4, 25);
    repeat (3) @(negedge clk);
    chk(sq8 == held, "R10", sq8, held);
    chk(ov8 == 1'b0, "R10", ov8, 0);
    inValid = 1'b1;
    @(negedge clk);
    chk(sq8 == 16'd40000, "R8", sq8, 40000);

    finished = 1'b1;
    summary();
  end
endmodule